// File: doc/BRIEF.md
# T1/E1 Receive Frame and Multiframe Sync Generator

This block sits on the receive side of a T1/E1 framer and produces sync pulses that line up with the serial bit stream. It runs on the bit clock (1.544 MHz for T1, 2.048 MHz for E1). Two internal counters track where the stream is: a bit counter inside the frame and a frame counter inside the multiframe. The pulses are decoded from the next values of these counters and registered, so each pulse shows up in the same clock cycle as the bit it marks.

There are two outputs. A shared output carries either the frame pulse or the multiframe pulse. A second sync pin is bidirectional. When it drives, it can mark frames, T1 multiframes, T1 signaling frames with a two-bit-wide pulse, or E1 multiframes aligned either to the CAS phase or to a CRC-4 phase. The CRC-4 phase is set apart from the CAS phase by a programmable frame offset. When the pin senses, the output enable drops, and a pulse arriving on the pin moves the counters to a new boundary. In frame mode only the bit position moves. In multiframe mode the frame position moves as well.

Top module: `sync_gen`

## Requirements
- R1: With `fms_sel_mf`=0, `fms_out` is high for exactly one cycle at the first bit of every frame. A frame is 193 cycles in T1 (`e1_mode`=0) and 256 cycles in E1 (`e1_mode`=1).
- R2: With `fms_sel_mf`=1, `fms_out` is high for one cycle at the first bit of frame 0 of each multiframe. A multiframe is 12 frames in T1 and 16 frames in E1.
- R3: `fms_sel_mf` picks the content of `fms_out`: 0 gives the frame pulse and 1 gives the multiframe pulse.
- R4: With `pin_sense`=0 and `boundary_mf`=0, `sync_oe` is 1 and `sync_out` pulses at the first bit of every frame. In E1, or in T1 with `width_crc`=0, this pulse is one cycle wide.
- R5: In T1 with `pin_sense`=0 and `boundary_mf`=1, `sync_out` pulses only at bit 0 of frame 0, and `width_crc` has no effect on it.
- R6: In T1 with `pin_sense`=0, `boundary_mf`=0 and `width_crc`=1, `sync_out` is also high at bit 1 of the signaling frames. These are frame indices 5 and 11 (the 6th and 12th frames), so the pulse there is two cycles wide.
- R7: In E1 with `pin_sense`=0 and `boundary_mf`=1, `sync_out` pulses at bit 0 of frame 0 when `width_crc`=0 (CAS phase). When `width_crc`=1 it pulses at bit 0 of frame `crc_offset` (CRC-4 phase).
- R8: In E1 frame mode (`boundary_mf`=0), `width_crc` has no effect on `sync_out`.
- R9: With `pin_sense`=1, `sync_oe` and `sync_out` stay low. `sync_in` is sampled on the falling clock edge. In frame mode, a pulse seen during a cycle makes that cycle bit 0 of a frame, so the next frame pulse comes one frame length later.
- R10: With `pin_sense`=1 and `boundary_mf`=1, a pulse on `sync_in` makes its cycle bit 0 of frame 0, which realigns the multiframe as well.
- R11: During reset all outputs are low and the counters sit at bit 0 of frame 0. The first pulse follows one frame length (or one multiframe length) after the first clock edge.
- R12: Only a rising transition of the sampled `sync_in` realigns the counters. Holding it high for several cycles gives the same alignment as a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e1_mode | input | 1 | 0 = T1 line, 1 = E1 line |
| boundary_mf | input | 1 | Sync pin boundary: 0 = frame, 1 = multiframe |
| width_crc | input | 1 | T1 frame mode: two-cycle pulse at signaling frames; E1 multiframe: CRC-4 phase |
| pin_sense | input | 1 | 0 = sync pin drives, 1 = sync pin senses |
| fms_sel_mf | input | 1 | Shared output: 0 = frame pulse, 1 = multiframe pulse |
| crc_offset | input | 4 | Frame offset of the CRC-4 phase from the CAS phase |
| sync_in | input | 1 | External sync pulse, sampled on the falling edge |
| sync_out | output | 1 | Configurable sync pulse |
| sync_oe | output | 1 | Output enable of the sync pin |
| fms_out | output | 1 | Shared frame or multiframe sync pulse |

## Verification
The bench first sweeps every combination of boundary mode, width/CRC bit and shared select in both line modes. It compares each cycle for more than a full multiframe against bit and frame indices that it computes arithmetically from the edge count. This separates the one-cycle frame pulse from the two-cycle signaling-frame pulse and from the multiframe pulse. It also shows whether `width_crc` is ignored where it should be. The E1 sweep is repeated with offsets 0, 5 and 15, so a CRC-4 phase that coincides with the CAS phase is told apart from ones that lag it. Sense-direction runs apply a one-cycle pulse in the middle of a frame and a pulse held high for several cycles. These show that the frame realignment, the multiframe realignment and the rising-edge-only behaviour each move the boundaries to the expected cycle.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    typedef enum logic {
        PIN_DRIVE = 1'b0,
        PIN_SENSE = 1'b1
    } pin_dir_e;

    typedef struct packed {
        logic     e1;
        logic     mf;
        logic     aux;
        pin_dir_e dir;
        logic     shared_mf;
    } sync_cfg_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sync_gen_sampler.sv
module sync_gen_sampler #(
    parameter bit SAMPLE_FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise
);

    typedef struct packed {
        logic prev;
    } hist_t;

    logic  samp_q;
    hist_t hist_d, hist_q;

    generate
        if (SAMPLE_FALLING) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) samp_q <= 1'b0;
                else        samp_q <= pin_in;
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) samp_q <= 1'b0;
                else        samp_q <= pin_in;
            end
        end
    endgenerate

    always_comb begin
        hist_d      = hist_q;
        hist_d.prev = samp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign rise = samp_q & ~hist_q.prev;

endmodule

// File: rtl/sync_gen_counter.sv
module sync_gen_counter #(
    parameter int T1_FRAME_BITS = 193,
    parameter int E1_FRAME_BITS = 256,
    parameter int T1_MF_FRAMES  = 12,
    parameter int E1_MF_FRAMES  = 16,
    parameter int BIT_W         = 8,
    parameter int FRM_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e1_mode,
    input  logic             realign,
    input  logic             realign_mf,
    output logic [BIT_W-1:0] bit_q,
    output logic [FRM_W-1:0] frame_q,
    output logic [BIT_W-1:0] bit_nxt,
    output logic [FRM_W-1:0] frame_nxt
);

    localparam logic [BIT_W-1:0] T1_BIT_LAST = BIT_W'(T1_FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] E1_BIT_LAST = BIT_W'(E1_FRAME_BITS - 1);
    localparam logic [FRM_W-1:0] T1_FRM_LAST = FRM_W'(T1_MF_FRAMES - 1);
    localparam logic [FRM_W-1:0] E1_FRM_LAST = FRM_W'(E1_MF_FRAMES - 1);

    typedef struct packed {
        logic [BIT_W-1:0] bit_idx;
        logic [FRM_W-1:0] frm_idx;
    } pos_t;

    pos_t             pos_d, pos_q;
    logic [BIT_W-1:0] bit_last;
    logic [FRM_W-1:0] frm_last;
    logic [FRM_W-1:0] frm_inc;

    always_comb begin
        bit_last = e1_mode ? E1_BIT_LAST : T1_BIT_LAST;
        frm_last = e1_mode ? E1_FRM_LAST : T1_FRM_LAST;
        frm_inc  = (pos_q.frm_idx >= frm_last) ? '0 : pos_q.frm_idx + FRM_W'(1);

        pos_d = pos_q;
        if (realign) begin
            // the sensed cycle is bit 0, so the next one is bit 1
            pos_d.bit_idx = BIT_W'(1);
            if (realign_mf)                 pos_d.frm_idx = '0;
            else if (pos_q.bit_idx != '0)   pos_d.frm_idx = frm_inc;
        end else if (pos_q.bit_idx >= bit_last) begin
            pos_d.bit_idx = '0;
            pos_d.frm_idx = frm_inc;
        end else begin
            pos_d.bit_idx = pos_q.bit_idx + BIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign bit_q     = pos_q.bit_idx;
    assign frame_q   = pos_q.frm_idx;
    assign bit_nxt   = pos_d.bit_idx;
    assign frame_nxt = pos_d.frm_idx;

endmodule

// File: rtl/sync_gen_decode.sv
module sync_gen_decode
    import sync_gen_pkg::*;
#(
    parameter int T1_SIG_FRAME_A = 5,
    parameter int T1_SIG_FRAME_B = 11,
    parameter int BIT_W          = 8,
    parameter int FRM_W          = 4
) (
    input  sync_cfg_t        cfg,
    input  logic [FRM_W-1:0] crc_off,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [FRM_W-1:0] frm_idx,
    output logic             pin_pulse,
    output logic             shared_pulse
);

    localparam logic [FRM_W-1:0] SIG_A = FRM_W'(T1_SIG_FRAME_A);
    localparam logic [FRM_W-1:0] SIG_B = FRM_W'(T1_SIG_FRAME_B);

    logic at_frame;
    logic at_cas;
    logic at_crc;
    logic sig_tail;

    always_comb begin
        at_frame = (bit_idx == '0);
        at_cas   = at_frame && (frm_idx == '0);
        at_crc   = at_frame && (frm_idx == crc_off);
        sig_tail = !cfg.e1 && cfg.aux && (bit_idx == BIT_W'(1))
                   && ((frm_idx == SIG_A) || (frm_idx == SIG_B));

        if (cfg.dir == PIN_SENSE)   pin_pulse = 1'b0;
        else if (!cfg.mf)           pin_pulse = at_frame || sig_tail;
        else if (cfg.e1 && cfg.aux) pin_pulse = at_crc;
        else                        pin_pulse = at_cas;

        shared_pulse = cfg.shared_mf ? at_cas : at_frame;
    end

endmodule

// File: rtl/sync_gen.sv
module sync_gen
    import sync_gen_pkg::*;
#(
    parameter int T1_FRAME_BITS  = 193,
    parameter int E1_FRAME_BITS  = 256,
    parameter int T1_MF_FRAMES   = 12,
    parameter int E1_MF_FRAMES   = 16,
    parameter int T1_SIG_FRAME_A = 5,
    parameter int T1_SIG_FRAME_B = 11,
    parameter bit SAMPLE_FALLING = 1'b1,
    localparam int BIT_W = $clog2(max_of(T1_FRAME_BITS, E1_FRAME_BITS)),
    localparam int FRM_W = $clog2(max_of(T1_MF_FRAMES, E1_MF_FRAMES))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e1_mode,
    input  logic             boundary_mf,
    input  logic             width_crc,
    input  logic             pin_sense,
    input  logic             fms_sel_mf,
    input  logic [FRM_W-1:0] crc_offset,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             sync_oe,
    output logic             fms_out
);

    typedef struct packed {
        logic pin;
        logic oe;
        logic shared;
    } outs_t;

    sync_cfg_t        cfg;
    logic             ext_rise;
    logic             realign;
    logic [BIT_W-1:0] bit_q;
    logic [FRM_W-1:0] frame_q;
    logic [BIT_W-1:0] bit_nxt;
    logic [FRM_W-1:0] frame_nxt;
    logic             pin_pulse;
    logic             shared_pulse;
    outs_t            outs_d, outs_q;

    always_comb begin
        cfg.e1        = e1_mode;
        cfg.mf        = boundary_mf;
        cfg.aux       = width_crc;
        cfg.dir       = pin_sense ? PIN_SENSE : PIN_DRIVE;
        cfg.shared_mf = fms_sel_mf;
    end

    sync_gen_sampler #(
        .SAMPLE_FALLING(SAMPLE_FALLING)
    ) u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(sync_in),
        .rise  (ext_rise)
    );

    assign realign = ext_rise && (cfg.dir == PIN_SENSE);

    sync_gen_counter #(
        .T1_FRAME_BITS(T1_FRAME_BITS),
        .E1_FRAME_BITS(E1_FRAME_BITS),
        .T1_MF_FRAMES (T1_MF_FRAMES),
        .E1_MF_FRAMES (E1_MF_FRAMES),
        .BIT_W        (BIT_W),
        .FRM_W        (FRM_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .e1_mode   (e1_mode),
        .realign   (realign),
        .realign_mf(boundary_mf),
        .bit_q     (bit_q),
        .frame_q   (frame_q),
        .bit_nxt   (bit_nxt),
        .frame_nxt (frame_nxt)
    );

    sync_gen_decode #(
        .T1_SIG_FRAME_A(T1_SIG_FRAME_A),
        .T1_SIG_FRAME_B(T1_SIG_FRAME_B),
        .BIT_W         (BIT_W),
        .FRM_W         (FRM_W)
    ) u_dec (
        .cfg         (cfg),
        .crc_off     (crc_offset),
        .bit_idx     (bit_nxt),
        .frm_idx     (frame_nxt),
        .pin_pulse   (pin_pulse),
        .shared_pulse(shared_pulse)
    );

    always_comb begin
        outs_d        = outs_q;
        outs_d.pin    = pin_pulse;
        outs_d.oe     = (cfg.dir == PIN_DRIVE);
        outs_d.shared = shared_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) outs_q <= '0;
        else        outs_q <= outs_d;
    end

    assign sync_out = outs_q.pin;
    assign sync_oe  = outs_q.oe;
    assign fms_out  = outs_q.shared;

endmodule

// File: rtl/sync_gen_chk.sv
module sync_gen_chk #(
    parameter int T1_FRAME_BITS = 193,
    parameter int E1_FRAME_BITS = 256,
    parameter int T1_MF_FRAMES  = 12,
    parameter int E1_MF_FRAMES  = 16,
    parameter int BIT_W         = 8,
    parameter int FRM_W         = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             e1_mode,
    input logic             boundary_mf,
    input logic             width_crc,
    input logic             pin_sense,
    input logic             sync_out,
    input logic             sync_oe,
    input logic             fms_out,
    input logic [BIT_W-1:0] bit_q,
    input logic [FRM_W-1:0] frame_q
);

    logic [3:0] cfg_now;
    logic [3:0] cfg_q1;
    logic [3:0] cfg_q2;
    logic       cfg_steady;

    assign cfg_now    = {e1_mode, boundary_mf, width_crc, pin_sense};
    assign cfg_steady = (cfg_now == cfg_q1) && (cfg_q1 == cfg_q2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q1 <= cfg_now;
            cfg_q2 <= cfg_now;
        end else begin
            cfg_q1 <= cfg_now;
            cfg_q2 <= cfg_q1;
        end
    end

    // R1
    fms_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fms_out |=> !fms_out);

    // R1
    fms_on_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fms_out |-> (bit_q == '0));

    // R9
    sense_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_oe |-> !sync_out);

    // R6
    doublewide_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out && (bit_q == BIT_W'(1)) && cfg_steady) |-> $past(sync_out));

    // R11
    bit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(e1_mode) |-> (int'(bit_q) < (e1_mode ? E1_FRAME_BITS : T1_FRAME_BITS)));

    // R2
    frame_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(e1_mode) |-> (int'(frame_q) < (e1_mode ? E1_MF_FRAMES : T1_MF_FRAMES)));

endmodule

bind sync_gen sync_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .e1_mode    (e1_mode),
    .boundary_mf(boundary_mf),
    .width_crc  (width_crc),
    .pin_sense  (pin_sense),
    .sync_out   (sync_out),
    .sync_oe    (sync_oe),
    .fms_out    (fms_out),
    .bit_q      (bit_q),
    .frame_q    (frame_q)
);

// File: tb/tb_sync_gen.sv
module tb_sync_gen;

    localparam int T1_FB = 193;
    localparam int E1_FB = 256;
    localparam int T1_MF = 12;
    localparam int E1_MF = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e1_mode = 1'b0;
    logic       boundary_mf = 1'b0;
    logic       width_crc = 1'b0;
    logic       pin_sense = 1'b0;
    logic       fms_sel_mf = 1'b0;
    logic [3:0] crc_offset = 4'd0;
    logic       sync_in = 1'b0;
    logic       sync_out;
    logic       sync_oe;
    logic       fms_out;

    int      checks = 0;
    int      errors = 0;
    longint  n  = 0;
    longint  n0 = 0;

    always #4 clk = ~clk;

    sync_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .e1_mode    (e1_mode),
        .boundary_mf(boundary_mf),
        .width_crc  (width_crc),
        .pin_sense  (pin_sense),
        .fms_sel_mf (fms_sel_mf),
        .crc_offset (crc_offset),
        .sync_in    (sync_in),
        .sync_out   (sync_out),
        .sync_oe    (sync_oe),
        .fms_out    (fms_out)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual=still running expected=finished");
        finish_run();
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual=%b expected=%b", req, what, n, act, exp);
        end
    endtask

    task automatic do_reset(input logic e1, input logic mf, input logic aux,
                            input logic sense, input logic shmf, input logic [3:0] off);
        rst_n       = 1'b0;
        sync_in     = 1'b0;
        e1_mode     = e1;
        boundary_mf = mf;
        width_crc   = aux;
        pin_sense   = sense;
        fms_sel_mf  = shmf;
        crc_offset  = off;
        repeat (3) @(posedge clk);
        #2;
        // R11: outputs held low in reset
        chk("R11", "sync_out in reset", sync_out, 1'b0);
        chk("R11", "sync_oe in reset",  sync_oe,  1'b0);
        chk("R11", "fms_out in reset",  fms_out,  1'b0);
        rst_n = 1'b1;
        n  = 0;
        n0 = 0;
    endtask

    // compare all outputs after edge n against arithmetic indices
    task automatic check_now(input string tag);
        int fb;
        int mf;
        int b;
        int f;
        logic exp_pin;
        logic exp_sh;
        string rp;
        string rs;
        fb = e1_mode ? E1_FB : T1_FB;
        mf = e1_mode ? E1_MF : T1_MF;
        b  = int'((n - n0) % fb);
        f  = int'(((n - n0) / fb) % mf);
        if (pin_sense) begin
            exp_pin = 1'b0; rp = "R9";
        end else if (!boundary_mf) begin
            exp_pin = (b == 0) || (!e1_mode && width_crc && b == 1 && (f == 5 || f == 11));
            rp = (!e1_mode && width_crc) ? "R6" : (e1_mode && width_crc) ? "R8" : "R4";
        end else if (e1_mode) begin
            exp_pin = (b == 0) && (f == (width_crc ? int'(crc_offset) : 0));
            rp = "R7";
        end else begin
            exp_pin = (b == 0) && (f == 0);
            rp = "R5";
        end
        exp_sh = fms_sel_mf ? ((b == 0) && (f == 0)) : (b == 0);
        rs = fms_sel_mf ? "R2 R3" : "R1 R3";
        if (n <= 0) begin
            exp_pin = 1'b0;
            exp_sh  = 1'b0;
        end
        if (tag != "") begin
            rp = tag;
            rs = tag;
        end
        chk(rp, "sync_out", sync_out, exp_pin);
        chk(rp, "sync_oe",  sync_oe,  !pin_sense);
        chk(rs, "fms_out",  fms_out,  exp_sh);
    endtask

    task automatic run(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            n++;
            #2;
            sync_in = 1'b0;
            check_now(tag);
        end
    endtask

    // hold sync_in high for len cycles; the first such cycle becomes bit 0
    task automatic pulse(input int len, input string tag);
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            n++;
            #2;
            check_now(tag);
            sync_in = 1'b1;
            if (i == 0) n0 = n;
        end
    endtask

    initial begin
        // T1 sweep: R1 R2 R3 R4 R5 R6 R11
        for (int mf = 0; mf < 2; mf++)
            for (int aux = 0; aux < 2; aux++)
                for (int sh = 0; sh < 2; sh++) begin
                    do_reset(1'b0, mf[0], aux[0], 1'b0, sh[0], 4'd0);
                    run(T1_FB * T1_MF + 2 * T1_FB, "");
                end

        // E1 sweep: R1 R2 R3 R4 R7 R8
        for (int mf = 0; mf < 2; mf++)
            for (int aux = 0; aux < 2; aux++)
                for (int sh = 0; sh < 2; sh++) begin
                    do_reset(1'b1, mf[0], aux[0], 1'b0, sh[0], 4'd5);
                    run(E1_FB * E1_MF + 2 * E1_FB, "");
                end

        // R7: CRC-4 phase equal to CAS phase, and the last possible offset
        do_reset(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
        run(E1_FB * E1_MF + 2 * E1_FB, "R7");
        do_reset(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd15);
        run(E1_FB * E1_MF + 2 * E1_FB, "R7");

        // R9: sense direction, frame mode realign in mid-frame (T1)
        do_reset(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
        run(500, "R9");
        pulse(1, "R9");
        run(3 * T1_FB, "R9");

        // R10: sense direction, multiframe realign (E1)
        do_reset(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0);
        run(1000, "R10");
        pulse(1, "R10");
        run(E1_FB * E1_MF + 300, "R10");

        // R12: a held-high input realigns only at its first cycle
        do_reset(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
        run(100, "R12");
        pulse(5, "R12");
        run(2 * T1_FB, "R12");

        finish_run();
    end

endmodule